// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware half of a receive ring whose entries pass between software and hardware through a single ownership bit. It keeps a small table of 64-bit descriptor control words, eight by default. Software reaches the table through a 32-bit register port that reads and writes one half-word at a time. Frames arrive one byte per cycle on a stream with a last-byte flag and three error flags. For each frame the engine checks who owns the current descriptor when the first byte arrives. If hardware owns it, the engine counts and classifies the bytes and writes length and status into the descriptor's low word when the frame ends. It then gives the descriptor back to software and steps to the next entry. If software owns it, the frame is thrown away and a no-buffer pulse is raised.

Each descriptor's high word belongs to software alone. It carries the end-of-ring marker and the buffer size, and the engine only reads it. Bytes beyond the buffer size are not counted, and the frame is then marked too long. The frame data itself is not stored here: moving bytes into a buffer memory is left to a neighbouring block.

Top module: `rxring_top`

## Requirements
- R1: After a synchronous active-high reset, every descriptor word reads back as zero, the ring index is 0, and both `irq_rxok` and `irq_nobuf` are low.
- R2: A port write with `sw_we` high updates one 32-bit half of the descriptor selected by `sw_addr[IW:1]`. Address bit 0 selects the half: 0 is control bits 31:0 and 1 is bits 63:32. Read data for the current `sw_addr` appears on `sw_rdata` one cycle later.
- R3: If the current descriptor has bit 31 = 1 (hardware owns it) when a frame's first byte arrives, the frame is accepted. On the edge that takes the last byte, the low word is replaced in a single step: bit 31 is cleared, bits 29 and 28 are set, bits 10:0 hold the length, the status flags are written, and every other low bit is 0. `irq_rxok` is high for exactly the one cycle that follows.
- R4: Length is the number of bytes received, limited to the buffer size held in bits 42:32 (high-word bits 10:0). If more bytes arrive than the buffer holds, the length equals the size and bit 20 is set.
- R5: If the length is below `MIN_FRAME` (64) and the frame is not too long, bit 21 (runt) is set.
- R6: The error inputs are sampled with the last byte and land in the status as follows: odd nibble in bit 22, CRC error in bit 19, bus error in bit 18.
- R7: Bit 17 (broadcast) is set when the first six bytes are all 0xFF. Bit 16 (multicast) is set when bit 0 of the first byte is 1 and the frame is not broadcast.
- R8: After a writeback, the ring index moves to the next entry. It returns to 0 instead when the used descriptor has bit 63 set or is the last table entry.
- R9: If the current descriptor has bit 31 = 0 when a frame's first byte arrives, the whole frame is dropped. The descriptor and the index stay as they were, `irq_nobuf` is high for exactly one cycle after the first byte, and `irq_rxok` stays low.
- R10: The engine never changes a descriptor's high word, so the end marker and the buffer size survive every writeback.
- R11: If a software write to a low word lands on the same edge as a writeback to that same descriptor, the writeback value is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Register write strobe |
| sw_addr | input | $clog2(NUM_DESC)+1 | Descriptor index (upper bits) and half select (bit 0) |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Byte valid on the receive stream |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_odd_nib | input | 1 | Odd-nibble error, sampled with the last byte |
| rx_crc_err | input | 1 | CRC error, sampled with the last byte |
| rx_bus_err | input | 1 | Bus error, sampled with the last byte |
| irq_rxok | output | 1 | One-cycle pulse after each writeback |
| irq_nobuf | output | 1 | One-cycle pulse when a frame is dropped for lack of a descriptor |

## Verification
The bench runs frames that stop short of, land exactly on, and run past the buffer size. A design that counted past the size, or failed to flag the overrun, would write a wrong length or miss bit 20.

The ring is first run with an end marker partway down the table and then with no marker at all. An index that ignored the marker, or ran off the end of the table, would write back into the wrong entry.

Descriptors are handed back carrying stale status bits, so any low bit the engine fails to overwrite shows up on readback. Software-owned entries are scattered at random among the frames: an engine that wrote anyway, or advanced past a dropped frame, would corrupt the descriptor, raise the wrong interrupt, or put the next frame in the wrong place. One-byte frames test the case where the ownership decision and the writeback happen on the same edge. One of them also arrives together with a software write to the same low word.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int LEN_W   = 11;
  localparam int B_OWN   = 31;
  localparam int B_FIRST = 29;
  localparam int B_LASTD = 28;
  localparam int B_ODD   = 22;
  localparam int B_RUNT  = 21;
  localparam int B_LONG  = 20;
  localparam int B_CRC   = 19;
  localparam int B_BUS   = 18;
  localparam int B_BC    = 17;
  localparam int B_MC    = 16;
  localparam int B_END   = 31;  // within the high word

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic odd;
    logic runt;
    logic too_long;
    logic crc;
    logic bus;
    logic bc;
    logic mc;
  } rx_result_t;

  // Low control word as written back: owner cleared, single-descriptor frame.
  function automatic logic [31:0] pack_status(rx_result_t r);
    logic [31:0] w;
    w = '0;
    w[B_FIRST] = 1'b1;
    w[B_LASTD] = 1'b1;
    w[B_ODD]   = r.odd;
    w[B_RUNT]  = r.runt;
    w[B_LONG]  = r.too_long;
    w[B_CRC]   = r.crc;
    w[B_BUS]   = r.bus;
    w[B_BC]    = r.bc;
    w[B_MC]    = r.mc;
    w[LEN_W-1:0] = r.len;
    return w;
  endfunction
endpackage

// File: rtl/rxring_table.sv
module rxring_table #(
  parameter int NUM_DESC = 8,
  parameter int IW = $clog2(NUM_DESC)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sw_we,
  input  logic [IW-1:0]               sw_idx,
  input  logic                        sw_half,
  input  logic [31:0]                 sw_wdata,
  output logic [31:0]                 sw_rdata,
  input  logic                        wb_en,
  input  logic [IW-1:0]               wb_idx,
  input  logic [31:0]                 wb_lo,
  input  logic [IW-1:0]               cur_idx,
  output logic                        cur_own,
  output logic                        cur_end,
  output logic [rxring_pkg::LEN_W-1:0] cur_size
);
  import rxring_pkg::*;

  logic [31:0] lo_q [NUM_DESC];
  logic [31:0] hi_q [NUM_DESC];
  logic        sw_lo_blocked;

  assign sw_lo_blocked = wb_en && (wb_idx == sw_idx);
  assign cur_own  = lo_q[cur_idx][B_OWN];
  assign cur_end  = hi_q[cur_idx][B_END];
  assign cur_size = hi_q[cur_idx][LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
      sw_rdata <= '0;
    end else begin
      sw_rdata <= sw_half ? hi_q[sw_idx] : lo_q[sw_idx];
      if (sw_we && sw_half) hi_q[sw_idx] <= sw_wdata;
      if (sw_we && !sw_half && !sw_lo_blocked) lo_q[sw_idx] <= sw_wdata;
      if (wb_en) lo_q[wb_idx] <= wb_lo;
    end
  end

  // R3: descriptor goes back to software in the writeback step
  a_r3_owner_released: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> !lo_q[$past(wb_idx)][B_OWN]);
  // R11: the writeback value survives a colliding software write
  a_r11_wb_wins: assert property (@(posedge clk) disable iff (rst)
    (wb_en && sw_we && !sw_half && sw_idx == wb_idx) |=> lo_q[$past(wb_idx)] == $past(wb_lo));
endmodule

// File: rtl/rxring_frame.sv
module rxring_frame #(
  parameter int MIN_FRAME = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         beat,
  input  logic                         first,
  input  logic [7:0]                   data,
  input  logic [rxring_pkg::LEN_W-1:0] buf_size,
  output logic [rxring_pkg::LEN_W-1:0] fin_len,
  output logic                         fin_long,
  output logic                         fin_runt,
  output logic                         fin_bc,
  output logic                         fin_mc
);
  import rxring_pkg::*;
  localparam int HDR = 6;
  localparam int HW  = $clog2(HDR + 1);

  logic [LEN_W-1:0] cnt_q, b_cnt, n_cnt;
  logic [HW-1:0]    hpos_q, b_hpos, n_hpos;
  logic             over_q, bc_q, mc_q;
  logic             b_over, b_bc, b_mc, n_over, n_bc, n_mc, room;

  always_comb begin
    b_cnt  = first ? '0   : cnt_q;
    b_hpos = first ? '0   : hpos_q;
    b_over = first ? 1'b0 : over_q;
    b_bc   = first ? 1'b1 : bc_q;
    b_mc   = first ? 1'b0 : mc_q;
    room   = b_cnt < buf_size;
    n_cnt  = room ? b_cnt + 1'b1 : b_cnt;
    n_over = b_over | !room;
    n_bc   = b_bc;
    n_mc   = b_mc;
    n_hpos = b_hpos;
    if (b_hpos < HW'(HDR)) begin
      n_bc   = b_bc & (data == 8'hFF);
      n_hpos = b_hpos + 1'b1;
    end
    if (b_hpos == '0) n_mc = data[0];
  end

  assign fin_len  = n_cnt;
  assign fin_long = n_over;
  assign fin_bc   = n_bc && (n_hpos == HW'(HDR));
  assign fin_mc   = n_mc && !fin_bc;
  assign fin_runt = !n_over && (n_cnt < LEN_W'(MIN_FRAME));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0; hpos_q <= '0; over_q <= 1'b0; bc_q <= 1'b0; mc_q <= 1'b0;
    end else if (beat) begin
      cnt_q <= n_cnt; hpos_q <= n_hpos; over_q <= n_over; bc_q <= n_bc; mc_q <= n_mc;
    end
  end

  // R4: reported length never exceeds the buffer
  a_r4_len_capped: assert property (@(posedge clk) disable iff (rst)
    beat |-> fin_len <= buf_size);
  // R5: runt and too-long never both
  a_r5_runt_excl: assert property (@(posedge clk) disable iff (rst)
    beat |-> !(fin_runt && fin_long));
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl #(
  parameter int NUM_DESC = 8,
  parameter int IW = $clog2(NUM_DESC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_last,
  input  logic          cur_own,
  input  logic          cur_end,
  output logic [IW-1:0] cur_idx,
  output logic          first_beat,
  output logic          wb_en,
  output logic          irq_rxok,
  output logic          irq_nobuf
);
  logic in_frame, accept_q, accept_now, wrap;

  assign first_beat = rx_valid && !in_frame;
  assign accept_now = first_beat ? cur_own : accept_q;
  assign wb_en      = rx_valid && rx_last && accept_now;
  assign wrap       = cur_end || (cur_idx == IW'(NUM_DESC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0; accept_q <= 1'b0; cur_idx <= '0;
      irq_rxok <= 1'b0; irq_nobuf <= 1'b0;
    end else begin
      if (rx_valid) in_frame <= !rx_last;
      if (first_beat) accept_q <= cur_own;
      irq_rxok  <= wb_en;
      irq_nobuf <= first_beat && !cur_own;
      if (wb_en) cur_idx <= wrap ? '0 : cur_idx + 1'b1;
    end
  end

  // R8: wrap on end marker
  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (wb_en && cur_end) |=> cur_idx == '0);
  // R8: plain step to next entry
  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !cur_end && cur_idx != IW'(NUM_DESC - 1)) |=> cur_idx == $past(cur_idx) + 1'b1);
  // R9: index holds without a writeback
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !wb_en |=> $stable(cur_idx));
  // R9: the two interrupt pulses never coincide
  a_r9_irq_excl: assert property (@(posedge clk) disable iff (rst)
    !(irq_rxok && irq_nobuf));
endmodule

// File: rtl/rxring_top.sv
module rxring_top #(
  parameter int NUM_DESC  = 8,
  parameter int MIN_FRAME = 64,
  parameter int IW = $clog2(NUM_DESC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_we,
  input  logic [IW:0]   sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_odd_nib,
  input  logic          rx_crc_err,
  input  logic          rx_bus_err,
  output logic          irq_rxok,
  output logic          irq_nobuf
);
  import rxring_pkg::*;

  logic [IW-1:0]    cur_idx;
  logic             cur_own, cur_end, first_beat, wb_en;
  logic [LEN_W-1:0] cur_size;
  rx_result_t       res;
  logic [31:0]      wb_lo;

  rxring_table #(.NUM_DESC(NUM_DESC), .IW(IW)) u_table (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_idx(sw_addr[IW:1]), .sw_half(sw_addr[0]),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .wb_en(wb_en), .wb_idx(cur_idx),
    .wb_lo(wb_lo), .cur_idx(cur_idx), .cur_own(cur_own), .cur_end(cur_end),
    .cur_size(cur_size));

  rxring_frame #(.MIN_FRAME(MIN_FRAME)) u_frame (
    .clk(clk), .rst(rst), .beat(rx_valid), .first(first_beat), .data(rx_data),
    .buf_size(cur_size), .fin_len(res.len), .fin_long(res.too_long),
    .fin_runt(res.runt), .fin_bc(res.bc), .fin_mc(res.mc));

  assign res.odd = rx_odd_nib;
  assign res.crc = rx_crc_err;
  assign res.bus = rx_bus_err;
  assign wb_lo   = pack_status(res);

  rxring_ctrl #(.NUM_DESC(NUM_DESC), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_last(rx_last),
    .cur_own(cur_own), .cur_end(cur_end), .cur_idx(cur_idx),
    .first_beat(first_beat), .wb_en(wb_en), .irq_rxok(irq_rxok),
    .irq_nobuf(irq_nobuf));
endmodule

// File: tb/tb_rxring_top.sv
module tb_rxring_top;
  localparam int N = 8;
  logic clk = 0, rst = 1;
  logic sw_we = 0;
  logic [3:0] sw_addr = 0;
  logic [31:0] sw_wdata = 0, sw_rdata;
  logic rx_valid = 0, rx_last = 0, rx_odd_nib = 0, rx_crc_err = 0, rx_bus_err = 0;
  logic [7:0] rx_data = 0;
  logic irq_rxok, irq_nobuf;

  int nchk = 0, nfail = 0;
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];
  int m_idx = 0;

  always #2 clk = ~clk;

  rxring_top dut (.clk(clk), .rst(rst), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_odd_nib(rx_odd_nib), .rx_crc_err(rx_crc_err),
    .rx_bus_err(rx_bus_err), .irq_rxok(irq_rxok), .irq_nobuf(irq_nobuf));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit half, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1; sw_addr = {3'(idx), half}; sw_wdata = d;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic rd(input int idx, input bit half, output logic [31:0] d);
    @(negedge clk);
    sw_we = 0; sw_addr = {3'(idx), half};
    @(negedge clk);
    d = sw_rdata;
  endtask

  function automatic logic [31:0] exp_lo(int n, int sz, bit bc, bit b0odd,
                                         bit eo, bit ec, bit eb);
    logic [31:0] w;
    int cnt;
    bit over, runt;
    cnt  = (n > sz) ? sz : n;
    over = n > sz;
    runt = !over && cnt < 64;
    w = 32'h3000_0000;
    w[22] = eo; w[21] = runt; w[20] = over; w[19] = ec; w[18] = eb;
    w[17] = bc; w[16] = b0odd && !bc;
    w[10:0] = 11'(cnt);
    return w;
  endfunction

  // Send a frame of n bytes; returns counts of irq pulses seen.
  task automatic send(input int n, input bit bcast, input bit odd0,
                      input bit eo, input bit ec, input bit eb, input bit clash,
                      output bit all_ff, output int nb, output int ok);
    logic [7:0] b;
    all_ff = (n >= 6); nb = 0; ok = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin nb += int'(irq_nobuf); ok += int'(irq_rxok); end
      b = 8'($urandom);
      if (bcast && i < 6) b = 8'hFF;
      else if (i == 0) b = odd0 ? (b | 8'h01) : (b & 8'hFE);
      if (i < 6 && b != 8'hFF) all_ff = 0;
      rx_valid = 1; rx_data = b; rx_last = (i == n - 1);
      rx_odd_nib = (i == n - 1) && eo;
      rx_crc_err = (i == n - 1) && ec;
      rx_bus_err = (i == n - 1) && eb;
      if (clash && i == n - 1) begin
        sw_we = 1; sw_addr = {3'(m_idx), 1'b0}; sw_wdata = 32'h8000_0ABC;
      end
    end
    @(negedge clk);
    nb += int'(irq_nobuf); ok += int'(irq_rxok);
    rx_valid = 0; rx_last = 0; rx_odd_nib = 0; rx_crc_err = 0; rx_bus_err = 0; sw_we = 0;
    @(negedge clk);
    nb += int'(irq_nobuf); ok += int'(irq_rxok);
  endtask

  task automatic frame_round(input bit clash, input bit force_drop);
    bit drop, bc_exp, odd0, bcast, eo, ec, eb, all_ff;
    int n, nb, ok, used;
    logic [31:0] stale, got;
    drop  = force_drop ? 1'b1 : (($urandom % 4) == 0) && !clash;
    stale = $urandom & 32'h7FFF_FFFF;
    m_lo[m_idx] = drop ? stale : (stale | 32'h8000_0000);
    wr(m_idx, 0, m_lo[m_idx]);
    n = clash ? 1 : 1 + ($urandom % 150);
    bcast = ($urandom % 3) == 0;
    odd0 = $urandom % 2;
    eo = ($urandom % 4) == 0; ec = ($urandom % 4) == 0; eb = ($urandom % 4) == 0;
    used = m_idx;
    send(n, bcast, odd0, eo, ec, eb, clash, all_ff, nb, ok);
    bc_exp = all_ff;
    if (drop) begin
      check("R9 irq_nobuf pulses", 32'(nb), 32'd1);
      check("R9 no irq_rxok on drop", 32'(ok), 32'd0);
    end else begin
      m_lo[used] = exp_lo(n, int'(m_hi[used][10:0]), bc_exp, odd0 | (bcast && n >= 1), eo, ec, eb);
      check("R3 irq_rxok one pulse", 32'(ok), 32'd1);
      check("R9 no irq_nobuf", 32'(nb), 32'd0);
      m_idx = (m_hi[used][31] || used == N - 1) ? 0 : used + 1;
    end
    rd(used, 0, got);
    check(clash ? "R11 writeback wins" : "R3 R4 R5 R6 R7 R8 R9 low word", got, m_lo[used]);
    rd(used, 1, got);
    check("R10 high word kept", got, m_hi[used]);
  endtask

  initial begin
    logic [31:0] got;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 irq_rxok low", 32'(irq_rxok), 0);
    check("R1 irq_nobuf low", 32'(irq_nobuf), 0);
    rd(0, 0, got); check("R1 lo0 zero", got, 0);
    rd(7, 1, got); check("R1 hi7 zero", got, 0);
    // R2 port readback
    wr(3, 1, 32'h1234_5678); rd(3, 1, got); check("R2 hi write", got, 32'h1234_5678);
    rd(3, 0, got); check("R2 lo untouched", got, 0);
    // phase A: end marker at entry 5
    for (int i = 0; i < N; i++) begin
      m_hi[i] = {(i == 5), 20'd0, 11'(20 + ($urandom % 101))};
      wr(i, 1, m_hi[i]);
      m_lo[i] = 0; wr(i, 0, 0);
    end
    frame_round(0, 1);
    for (int k = 0; k < 40; k++) frame_round(0, 0);
    // phase B: no end marker, wrap at last entry
    for (int i = 0; i < N; i++) begin
      m_hi[i] = {1'b0, 20'd0, 11'(20 + ($urandom % 101))};
      wr(i, 1, m_hi[i]);
    end
    for (int k = 0; k < 40; k++) frame_round(0, 0);
    // R4 exact-fit: frame length equal to buffer size
    m_hi[m_idx] = {1'b0, 20'd0, 11'd70};
    wr(m_idx, 1, m_hi[m_idx]);
    begin
      bit aff; int nb, ok, u;
      u = m_idx;
      m_lo[u] = 32'h8000_0000; wr(u, 0, m_lo[u]);
      send(70, 0, 0, 0, 0, 0, 0, aff, nb, ok);
      m_lo[u] = exp_lo(70, 70, 0, 0, 0, 0, 0);
      m_idx = (u == N - 1) ? 0 : u + 1;
      rd(u, 0, got); check("R4 exact fit not long", got, m_lo[u]);
    end
    // R11 collision with single-byte frame
    frame_round(1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule